// File: doc/BRIEF.md
# Exact Supplier-Line Predictor with Conflict Demotion

The block keeps a set-associative table of the line addresses that the local node holds in a supplier coherence state. A snoop-side lookup uses it to decide whether the node must be snooped. Filling and clearing the table is not enough to make its answer exact. When a set is full and a new supplier line arrives, the least recently used entry has to be displaced. Before that happens, the block tells the node's cache controller to demote the displaced line to a non-supplier state. As a result, every line the table does not list is truly not a supplier, and every line it lists truly is.

The block is driven from three sides:
- **Insert.** The cache controller inserts each line that gains supplier status, together with a 2-bit state code.
- **Remove.** The cache controller removes a line when it is evicted, downgraded or invalidated.
- **Lookup.** The snoop path presents an address and reads a same-cycle hit flag and the stored state.

A displacement raises a demotion request that carries the victim address and a flag. The flag is set when the victim is dirty and needs a writeback before it is kept in the shared non-supplier state. The flag is clear when the victim was clean and is only silently demoted. Until the controller acknowledges the request, both the victim and the new line answer lookups as hits, and further inserts are held off.

The control is a two-state machine:
- **IDLE.** Inserts, removes and lookups are served. The transition `CONFLICT` (an accepted insert that misses a full set) moves to WAIT_ACK.
- **WAIT_ACK.** The demotion request is held. The transition `ACKED` (`dg_ack` high) writes the new line over the victim's way and returns to IDLE.

Top module: `exact_supplier_predictor`

## Requirements
- R1: After reset the table is empty: every lookup misses, `dg_req` is 0, and `ins_ready` is 1 whenever `rem_valid` is 0.
- R2: An accepted insert of an absent address into a set with a free way makes that address hit from the next cycle. `lk_state` then returns the code given at insert: 00 SG, 01 E, 10 D, 11 T.
- R3: An accepted insert of an address already in the table replaces its stored code, raises no demotion, and makes that entry the most recently used in its set.
- R4: A remove of a listed address makes it miss from the next cycle. A remove of an unlisted address changes no lookup result.
- R5: An insert into a full set picks the least recently used entry of the set as victim. From the next cycle `dg_req` is 1, `dg_addr` is the victim address, and `dg_wb` is 1 for codes 10 and 11 and 0 for codes 00 and 01.
- R6: While `dg_req` is 1 and unacknowledged, `dg_addr` and `dg_wb` stay unchanged, `ins_ready` is 0, and both the victim and the held new address hit on lookup. A remove of the victim in this interval is ignored.
- R7: A cycle with `dg_ack` high during a pending demotion ends it. From the next cycle the victim misses, the held address hits with its code, `dg_req` is 0, and inserts are accepted again.
- R8: In any cycle with `rem_valid` high, `ins_ready` is 0, so no insert is taken in that cycle.
- R9: A remove of the held new address during a pending demotion cancels it. After the acknowledge neither that address nor the victim hits.
- R10: Lookup is combinational: `lk_hit` and `lk_state` reflect the table and the held address in the same cycle as `lk_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Supplier line to record |
| ins_ready | output | 1 | Insert accepted this cycle when high with ins_valid |
| ins_addr | input | ADDR_W | Line address to record |
| ins_state | input | 2 | Supplier state code of the line |
| rem_valid | input | 1 | Line lost supplier status |
| rem_addr | input | ADDR_W | Line address to drop |
| lk_addr | input | ADDR_W | Snoop lookup address |
| lk_hit | output | 1 | Address is a supplier line in this node |
| lk_state | output | 2 | Stored code of the hitting entry |
| dg_req | output | 1 | Demotion of a displaced line requested |
| dg_addr | output | ADDR_W | Address of the line to demote |
| dg_wb | output | 1 | Demotion needs a writeback first |
| dg_ack | input | 1 | Cache controller finished the demotion |

## Verification
The assertions watch the demotion handshake on every cycle:
- the request stays up with stable address and writeback flag until it is acknowledged, and drops right after;
- inserts are refused while it is up or while a remove is present;
- a lookup of the victim address hits for as long as the request is pending.

Only the bench's scenarios can show the rest, because it depends on the history of inserts and removes:
- which entry is the least recently used victim;
- that a re-insert refreshes recency;
- that the held line becomes visible or is cancelled correctly at the acknowledge.

The bench's behavioural model, checked every cycle over directed and random traffic, covers these.

// File: rtl/sup_pred_pkg.sv
package sup_pred_pkg;
    typedef enum logic [1:0] {
        SUP_SG = 2'b00,
        SUP_E  = 2'b01,
        SUP_D  = 2'b10,
        SUP_T  = 2'b11
    } sup_state_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_WAIT_ACK = 1'b1
    } pred_fsm_e;

    // Dirty supplier states (D, T) need a writeback before demotion.
    function automatic logic needs_writeback(input logic [1:0] code);
        return code[1];
    endfunction
endpackage

// File: rtl/spx_set_match.sv
module spx_set_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 13,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]       vld_i,
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic                  hit_o,
    output logic [WAY_W-1:0]      way_o
);
    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_i[w] && tags_i[w*TAG_W +: TAG_W] == tag_i) begin
                hit_o = 1'b1;
                way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/spx_way_pick.sv
module spx_way_pick #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]       vld_i,
    input  logic [WAYS*WAY_W-1:0] ages_i,
    output logic                  free_o,
    output logic [WAY_W-1:0]      free_way_o,
    output logic [WAY_W-1:0]      lru_way_o
);
    // Lowest-numbered invalid way wins; the oldest age marks the LRU way.
    always_comb begin
        free_o     = 1'b0;
        free_way_o = '0;
        lru_way_o  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_i[w]) begin
                free_o     = 1'b1;
                free_way_o = WAY_W'(w);
            end
            if (ages_i[w*WAY_W +: WAY_W] == WAY_W'(WAYS - 1)) begin
                lru_way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/exact_supplier_predictor.sv
module exact_supplier_predictor
    import sup_pred_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 8,
    parameter int WAYS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [1:0]        ins_state,
    input  logic              rem_valid,
    input  logic [ADDR_W-1:0] rem_addr,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [1:0]        lk_state,
    output logic              dg_req,
    output logic [ADDR_W-1:0] dg_addr,
    output logic              dg_wb,
    input  logic              dg_ack
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int NPORT = 3; // 0 lookup, 1 insert, 2 remove

    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [1:0]       st_q  [SETS][WAYS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    pred_fsm_e state_q, state_d;

    logic [IDX_W-1:0]  vic_set;
    logic [WAY_W-1:0]  vic_way;
    logic [ADDR_W-1:0] vic_addr;
    logic [1:0]        vic_st;
    logic [ADDR_W-1:0] pend_addr;
    logic [1:0]        pend_st;
    logic              pend_live;

    logic [ADDR_W-1:0] q_addr [NPORT];
    logic              m_hit  [NPORT];
    logic [WAY_W-1:0]  m_way  [NPORT];

    assign q_addr[0] = lk_addr;
    assign q_addr[1] = ins_addr;
    assign q_addr[2] = rem_addr;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            logic [IDX_W-1:0]      sidx;
            logic [WAYS*TAG_W-1:0] tags_flat;
            assign sidx = q_addr[p][IDX_W-1:0];
            always_comb begin
                for (int w = 0; w < WAYS; w++) begin
                    tags_flat[w*TAG_W +: TAG_W] = tag_q[sidx][w];
                end
            end
            spx_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
                .vld_i  (vld_q[sidx]),
                .tags_i (tags_flat),
                .tag_i  (q_addr[p][ADDR_W-1:IDX_W]),
                .hit_o  (m_hit[p]),
                .way_o  (m_way[p])
            );
        end
    endgenerate

    logic [IDX_W-1:0] lk_idx, ins_idx, rem_idx;
    assign lk_idx  = lk_addr[IDX_W-1:0];
    assign ins_idx = ins_addr[IDX_W-1:0];
    assign rem_idx = rem_addr[IDX_W-1:0];

    logic [WAYS*WAY_W-1:0] ins_ages;
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            ins_ages[w*WAY_W +: WAY_W] = age_q[ins_idx][w];
        end
    end

    logic             ins_free;
    logic [WAY_W-1:0] free_way, lru_way;
    spx_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .vld_i      (vld_q[ins_idx]),
        .ages_i     (ins_ages),
        .free_o     (ins_free),
        .free_way_o (free_way),
        .lru_way_o  (lru_way)
    );

    logic waiting, ins_fire, pend_keep, rem_on_victim;
    assign waiting       = (state_q == ST_WAIT_ACK);
    assign ins_fire      = ins_valid && ins_ready;
    assign pend_keep     = pend_live && !(rem_valid && rem_addr == pend_addr);
    assign rem_on_victim = waiting && rem_idx == vic_set && m_way[2] == vic_way;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: CONFLICT and ACKED transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ins_fire && !m_hit[1] && !ins_free) state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (dg_ack) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ins_ready = 1'b0;
        dg_req    = 1'b0;
        unique case (state_q)
            ST_IDLE:     ins_ready = !rem_valid;
            ST_WAIT_ACK: dg_req    = 1'b1;
        endcase
        dg_addr  = vic_addr;
        dg_wb    = needs_writeback(vic_st);
        lk_hit   = m_hit[0] || (waiting && pend_live && lk_addr == pend_addr);
        lk_state = m_hit[0] ? st_q[lk_idx][m_way[0]] : pend_st;
    end

    // Recency update
    logic             touch_en;
    logic [IDX_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;
    always_comb begin
        touch_en  = 1'b0;
        touch_set = ins_idx;
        touch_way = m_hit[1] ? m_way[1] : free_way;
        if (!waiting && ins_fire && (m_hit[1] || ins_free)) begin
            touch_en = 1'b1;
        end else if (waiting && dg_ack && pend_keep) begin
            touch_en  = 1'b1;
            touch_set = vic_set;
            touch_way = vic_way;
        end
    end

    // Table and victim registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    st_q[s][w]  <= '0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
            vic_set   <= '0;
            vic_way   <= '0;
            vic_addr  <= '0;
            vic_st    <= '0;
            pend_addr <= '0;
            pend_st   <= '0;
            pend_live <= 1'b0;
        end else begin
            if (rem_valid && m_hit[2] && !rem_on_victim) begin
                vld_q[rem_idx][m_way[2]] <= 1'b0;
            end
            if (ins_fire) begin
                if (m_hit[1]) begin
                    st_q[ins_idx][m_way[1]] <= ins_state;
                end else if (ins_free) begin
                    vld_q[ins_idx][free_way] <= 1'b1;
                    tag_q[ins_idx][free_way] <= ins_addr[ADDR_W-1:IDX_W];
                    st_q[ins_idx][free_way]  <= ins_state;
                end else begin
                    vic_set   <= ins_idx;
                    vic_way   <= lru_way;
                    vic_addr  <= {tag_q[ins_idx][lru_way], ins_idx};
                    vic_st    <= st_q[ins_idx][lru_way];
                    pend_addr <= ins_addr;
                    pend_st   <= ins_state;
                    pend_live <= 1'b1;
                end
            end
            if (waiting && !pend_keep) begin
                pend_live <= 1'b0;
            end
            if (waiting && dg_ack) begin
                pend_live <= 1'b0;
                if (pend_keep) begin
                    tag_q[vic_set][vic_way] <= pend_addr[ADDR_W-1:IDX_W];
                    st_q[vic_set][vic_way]  <= pend_st;
                end else begin
                    vld_q[vic_set][vic_way] <= 1'b0;
                end
            end
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way) begin
                        age_q[touch_set][w] <= '0;
                    end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                        age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_ready,
    input logic              rem_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic              dg_req,
    input logic [ADDR_W-1:0] dg_addr,
    input logic              dg_wb,
    input logic              dg_ack
);
    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !dg_req);

    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dg_req && !dg_ack) |=> (dg_req && $stable(dg_addr) && $stable(dg_wb)));

    p_no_insert_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dg_req |-> !ins_ready);

    p_victim_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dg_req && lk_addr == dg_addr) |-> lk_hit);

    p_ack_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dg_req && dg_ack) |=> !dg_req);

    p_remove_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rem_valid |-> !ins_ready);
endmodule

bind exact_supplier_predictor spx_checker #(.ADDR_W(ADDR_W)) u_spx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_ready (ins_ready),
    .rem_valid (rem_valid),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .dg_req    (dg_req),
    .dg_addr   (dg_addr),
    .dg_wb     (dg_wb),
    .dg_ack    (dg_ack)
);

// File: tb/exact_supplier_predictor_test.sv
module exact_supplier_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int SETS       = 8;
    localparam int WAYS       = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic              ins_ready;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [1:0]        ins_state = '0;
    logic              rem_valid = 1'b0;
    logic [ADDR_W-1:0] rem_addr = '0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit;
    logic [1:0]        lk_state;
    logic              dg_req;
    logic [ADDR_W-1:0] dg_addr;
    logic              dg_wb;
    logic              dg_ack = 1'b0;

    exact_supplier_predictor #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) uut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_state(ins_state),
        .rem_valid(rem_valid), .rem_addr(rem_addr),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_state(lk_state),
        .dg_req(dg_req), .dg_addr(dg_addr), .dg_wb(dg_wb), .dg_ack(dg_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model: per set, addresses in recency order (front = most recent).
    logic [ADDR_W-1:0] qa [SETS][$];
    logic [1:0]        qs [SETS][$];
    bit                m_wait  = 0;
    bit                m_plive = 0;
    logic [ADDR_W-1:0] m_vaddr = '0, m_paddr = '0;
    logic [1:0]        m_vst = '0, m_pst = '0;

    function automatic int set_of(input logic [ADDR_W-1:0] a);
        return int'(a % SETS);
    endfunction

    function automatic int mfind(input logic [ADDR_W-1:0] a);
        int s = set_of(a);
        for (int i = 0; i < qa[s].size(); i++) if (qa[s][i] == a) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One clock: drive, compare against the model mid-cycle, update model at the edge.
    task automatic cyc(input string req, input bit iv, input logic [ADDR_W-1:0] ia, input logic [1:0] is,
                       input bit rv, input logic [ADDR_W-1:0] ra, input logic [ADDR_W-1:0] la, input bit ack);
        bit e_ready, e_hit;
        logic [1:0] e_st;
        int pos, s;
        ins_valid = iv; ins_addr = ia; ins_state = is;
        rem_valid = rv; rem_addr = ra; lk_addr = la; dg_ack = ack;
        #(CLK_PERIOD/2 - 1);
        e_ready = !m_wait && !rv;
        pos = mfind(la);
        e_hit = 0; e_st = '0;
        if (pos >= 0) begin e_hit = 1; e_st = qs[set_of(la)][pos]; end
        else if (m_wait && m_plive && la == m_paddr) begin e_hit = 1; e_st = m_pst; end
        chk(req, "ins_ready", 32'(ins_ready), 32'(e_ready));
        chk(req, "dg_req", 32'(dg_req), 32'(m_wait));
        if (m_wait) begin
            chk(req, "dg_addr", 32'(dg_addr), 32'(m_vaddr));
            chk(req, "dg_wb", 32'(dg_wb), 32'(m_vst[1]));
        end
        chk(req, "lk_hit", 32'(lk_hit), 32'(e_hit));
        if (e_hit) chk(req, "lk_state", 32'(lk_state), 32'(e_st));
        @(posedge clk);
        if (rv) begin
            if (m_wait && m_plive && ra == m_paddr) m_plive = 0;
            else begin
                pos = mfind(ra);
                if (pos >= 0 && !(m_wait && ra == m_vaddr)) begin
                    s = set_of(ra); qa[s].delete(pos); qs[s].delete(pos);
                end
            end
        end
        if (m_wait && ack) begin
            s = set_of(m_vaddr); pos = mfind(m_vaddr);
            qa[s].delete(pos); qs[s].delete(pos);
            if (m_plive) begin qa[s].push_front(m_paddr); qs[s].push_front(m_pst); end
            m_wait = 0; m_plive = 0;
        end else if (iv && e_ready) begin
            s = set_of(ia); pos = mfind(ia);
            if (pos >= 0) begin
                qa[s].delete(pos); qs[s].delete(pos);
                qa[s].push_front(ia); qs[s].push_front(is);
            end else if (qa[s].size() < WAYS) begin
                qa[s].push_front(ia); qs[s].push_front(is);
            end else begin
                m_wait = 1; m_plive = 1;
                m_vaddr = qa[s][$]; m_vst = qs[s][$];
                m_paddr = ia; m_pst = is;
            end
        end
        #1;
    endtask

    task automatic idle_look(input string req, input logic [ADDR_W-1:0] la);
        cyc(req, 0, '0, 2'b00, 0, '0, la, 0);
    endtask

    task automatic put(input string req, input logic [ADDR_W-1:0] a, input logic [1:0] st);
        cyc(req, 1, a, st, 0, '0, a, 0);
    endtask

    task automatic drop(input string req, input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] la);
        cyc(req, 0, '0, 2'b00, 1, a, la, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        // R1: reset state
        chk("R1", "dg_req in reset", 32'(dg_req), 32'd0);
        chk("R1", "ins_ready in reset", 32'(ins_ready), 32'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle_look("R1", 16'h0010);
        idle_look("R1", 16'h0000);

        // R2: fill free ways, R10 same-cycle lookup
        put("R2", 16'h0011, 2'b01);
        idle_look("R2", 16'h0011);
        put("R2", 16'h0019, 2'b10);
        idle_look("R10", 16'h0019);

        // R3: re-insert refreshes code and recency
        put("R3", 16'h0011, 2'b11);
        idle_look("R3", 16'h0011);

        // R5: conflict with dirty victim 0x0019
        put("R5", 16'h0021, 2'b00);
        // R6: waiting, victim and held both hit, inserts refused, victim remove ignored
        idle_look("R6", 16'h0019);
        idle_look("R6", 16'h0021);
        cyc("R6", 1, 16'h0031, 2'b01, 0, '0, 16'h0031, 0);
        drop("R6", 16'h0019, 16'h0019);
        idle_look("R6", 16'h0011);
        // R7: acknowledge
        cyc("R7", 0, '0, 2'b00, 0, '0, 16'h0019, 1);
        idle_look("R7", 16'h0019);
        idle_look("R7", 16'h0021);
        chk("R7", "held line visible", 32'(lk_hit), 32'd1);

        // R5: clean victim, recency decided by re-insert
        put("R5", 16'h0002, 2'b00);
        put("R5", 16'h000A, 2'b01);
        put("R3", 16'h0002, 2'b00);
        put("R5", 16'h0012, 2'b10);
        idle_look("R5", 16'h000A);
        chk("R5", "clean victim no writeback", 32'(dg_wb), 32'd0);
        chk("R5", "victim address", 32'(dg_addr), 32'h000A);
        cyc("R7", 0, '0, 2'b00, 0, '0, 16'h0012, 1);
        idle_look("R7", 16'h000A);

        // R4: removes
        drop("R4", 16'h0011, 16'h0011);
        idle_look("R4", 16'h0011);
        drop("R4", 16'h0099, 16'h0021);
        idle_look("R4", 16'h0021);
        idle_look("R4", 16'h0002);

        // R8: remove and insert in the same cycle
        cyc("R8", 1, 16'h0044, 2'b01, 1, 16'h0077, 16'h0044, 0);
        idle_look("R8", 16'h0044);

        // R9: cancel held insert
        put("R9", 16'h0003, 2'b11);
        put("R9", 16'h000B, 2'b01);
        put("R9", 16'h0013, 2'b10);
        drop("R9", 16'h0013, 16'h0013);
        idle_look("R9", 16'h0013);
        cyc("R9", 0, '0, 2'b00, 0, '0, 16'h0003, 1);
        idle_look("R9", 16'h0013);
        idle_look("R9", 16'h0003);
        chk("R9", "victim gone after cancel", 32'(lk_hit), 32'd0);
        idle_look("R9", 16'h000B);

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [ADDR_W-1:0] a, r, l;
            a = ADDR_W'((($urandom % 4) << 3) | ($urandom % 2) + 4);
            r = ADDR_W'((($urandom % 4) << 3) | ($urandom % 2) + 4);
            l = ADDR_W'((($urandom % 4) << 3) | ($urandom % 2) + 4);
            cyc("R2", ($urandom % 2) == 0, a, 2'($urandom % 4),
                ($urandom % 4) == 0, r, l, ($urandom % 3) == 0);
        end

        summary();
        $finish;
    end
endmodule